// File: doc/BRIEF.md
# Timer Waveform Generator Channel

This block is one channel of a general-purpose timer used to produce waveforms. A counter of configurable width (16 bits by default) advances by one step on each cycle in which the count-enable strobe is high. A 2-bit profile code chooses how the counter moves. It can wrap at its top value, restart at a programmable period register, run as a triangle between zero and the top value, or run as a triangle between zero and the period register. Three compare registers are loaded through a simple write port. The counter landing on one of them raises an event.

Two waveform lines are driven from these events. Every event source has its own 2-bit action code for each line. The sources are the first compare register, the second compare register, the period compare, an edge on the external event input, and a software or block trigger. A software trigger, a block trigger, or an external event with restart enabled returns the counter to zero and starts it counting upward. Options can halt the counter or switch its clock off when the period compare hits. Single-cycle status flags report each kind of event.

Top module: `tcw_channel`

## Requirements
- R1: After synchronous reset the counter reads 0, both waveform lines and all status flags are low, the channel clock is off and the channel is not running. Count strobes alone then leave the counter at 0.
- R2: The counter takes exactly one step for each rising clock edge at which `cnt_tick` is high while the channel clock is on and the channel is running. The new value appears at `cnt_val` after that edge. No other event moves it, except a restart, which sets it to 0.
- R3: Profile 00 counts upward and wraps from the all-ones value to 0. `st_covf` pulses for one cycle after every step taken from the all-ones value, in any profile.
- R4: Profile 01 counts upward. A step taken while the counter equals the period register (write select 10) goes to 0, so the count repeats with period RC+1 steps.
- R5: Profile 10 counts up to the all-ones value and then down to 0, repeatedly. The step after all-ones gives all-ones minus 1, and the step after 0 while counting down gives 1.
- R6: Profile 11 counts up to the period register value and then down to 0, repeatedly, with a period of 2·RC steps.
- R7: `st_cpa`, `st_cpb` and `st_cpc` pulse for one cycle after a step lands on the first compare, second compare or period register value. A restart never raises them. The two compare registers never change the counter's value or direction.
- R8: Action codes are 00 keep, 01 drive high, 10 drive low, 11 invert. The first compare acts only on `tio_a`, the second compare only on `tio_b`, and the period compare on both lines through separate codes.
- R9: A pulse on `sw_trig` or on `blk_trig` sets the counter to 0 with upward direction, marks the channel running, and applies the software-trigger action code of each line.
- R10: The external edge select is 00 none, 01 rising, 10 falling, 11 either, judged against the previous cycle's input level. A qualifying edge pulses `st_etrg` and applies the external action codes. When `cfg_etrg_en` is set, it also restarts the counter from 0.
- R11: When several events reach one line in the same cycle, the one applied is the highest-priority event whose code is not 00. The order, highest first, is software/block trigger, external event, period compare, then the line's own compare.
- R12: With `cfg_stop_rc` set, the period compare halts counting at that value. A later restart resumes counting.
- R13: With `cfg_dis_rc` set, the period compare switches the channel clock off. A restart alone does not resume counting; a `clk_on` pulse is needed as well.
- R14: Register writes with `wr_en` use select 00 for the first compare, 01 for the second compare and 10 for the period register. Select 11 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_tick | input | 1 | Count-enable strobe, one step per high cycle |
| sw_trig | input | 1 | Software trigger for this channel |
| blk_trig | input | 1 | Trigger shared by all channels of a block |
| ext_evt_in | input | 1 | External event line |
| clk_on | input | 1 | Switches the channel clock on |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 00 first compare, 01 second compare, 10 period, 11 none |
| wr_data | input | CNT_W | Write data |
| cfg_mode | input | 2 | Counting profile |
| cfg_ext_edge | input | 2 | External edge select |
| cfg_etrg_en | input | 1 | External event restarts the counter |
| cfg_stop_rc | input | 1 | Halt counting on period compare |
| cfg_dis_rc | input | 1 | Switch clock off on period compare |
| cfg_a_ra | input | 2 | First compare action on tio_a |
| cfg_a_rc | input | 2 | Period compare action on tio_a |
| cfg_a_ext | input | 2 | External event action on tio_a |
| cfg_a_sw | input | 2 | Software/block trigger action on tio_a |
| cfg_b_rb | input | 2 | Second compare action on tio_b |
| cfg_b_rc | input | 2 | Period compare action on tio_b |
| cfg_b_ext | input | 2 | External event action on tio_b |
| cfg_b_sw | input | 2 | Software/block trigger action on tio_b |
| cnt_val | output | CNT_W | Counter value |
| tio_a | output | 1 | Waveform line A |
| tio_b | output | 1 | Waveform line B |
| st_covf | output | 1 | Overflow pulse |
| st_cpa | output | 1 | First compare pulse |
| st_cpb | output | 1 | Second compare pulse |
| st_cpc | output | 1 | Period compare pulse |
| st_etrg | output | 1 | External event pulse |

## Verification
The bench builds the channel with `CNT_W` set to 4. At that width a full wrap takes 16 steps and a full triangle takes 30, so every turnaround and overflow point is reached many times in a short run. The period register is swept over every nonzero value from 1 to 15 in both period-based profiles. Each observed count is compared against a closed-form value computed from the step number. Waveform lines, priority conflicts, stop and disable behaviour, and the external edge codes are then checked at hand-picked counts within this small range.

// File: rtl/tcw_pkg.sv
package tcw_pkg;

    typedef enum logic [1:0] {
        MODE_UP_WRAP  = 2'b00,
        MODE_UP_RC    = 2'b01,
        MODE_UPDN_MAX = 2'b10,
        MODE_UPDN_RC  = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'b00,
        ACT_SET  = 2'b01,
        ACT_CLR  = 2'b10,
        ACT_TOG  = 2'b11
    } out_act_e;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_sel_e;

    typedef enum logic [1:0] {
        SEL_RA   = 2'b00,
        SEL_RB   = 2'b01,
        SEL_RC   = 2'b10,
        SEL_NONE = 2'b11
    } reg_sel_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;

    // events reaching one waveform line, ordered by priority (sw highest)
    typedef struct packed {
        logic sw;
        logic ext;
        logic rc;
        logic own;
    } line_evt_t;

    typedef struct packed {
        out_act_e sw;
        out_act_e ext;
        out_act_e rc;
        out_act_e own;
    } line_act_t;

    function automatic logic apply_act(input logic cur, input out_act_e act);
        case (act)
            ACT_SET:  return 1'b1;
            ACT_CLR:  return 1'b0;
            ACT_TOG:  return ~cur;
            default:  return cur;
        endcase
    endfunction

    // highest-priority present event with a non-keep code wins
    function automatic out_act_e pick_act(input line_evt_t e, input line_act_t a);
        if (e.sw  && a.sw  != ACT_KEEP) return a.sw;
        if (e.ext && a.ext != ACT_KEEP) return a.ext;
        if (e.rc  && a.rc  != ACT_KEEP) return a.rc;
        if (e.own && a.own != ACT_KEEP) return a.own;
        return ACT_KEEP;
    endfunction

endpackage

// File: rtl/tcw_edge_det.sv
module tcw_edge_det
    import tcw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sig_in,
    input  logic [1:0] edge_sel,
    output logic       evt
);

    logic sig_q;
    logic rise;
    logic fall;

    always_ff @(posedge clk) begin
        if (rst) sig_q <= 1'b0;
        else     sig_q <= sig_in;
    end

    assign rise = sig_in & ~sig_q;
    assign fall = ~sig_in & sig_q;

    always_comb begin
        case (edge_sel_e'(edge_sel))
            EDGE_RISE: evt = rise;
            EDGE_FALL: evt = fall;
            EDGE_ANY:  evt = rise | fall;
            default:   evt = 1'b0;
        endcase
    end

endmodule

// File: rtl/tcw_counter.sv
module tcw_counter
    import tcw_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         restart,
    input  logic         clk_on,
    input  logic [1:0]   mode,
    input  logic [W-1:0] rc,
    input  logic         stop_rc,
    input  logic         dis_rc,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_nxt,
    output logic         step,
    output logic         ovf,
    output logic         rc_hit
);

    localparam logic [W-1:0] TOP  = '1;
    localparam logic [W-1:0] ONE  = W'(1);

    logic [W-1:0] cnt_q;
    cnt_dir_e     dir_q;
    cnt_dir_e     dir_n;
    logic         en_q;
    logic         run_q;
    cnt_mode_e    mode_e;

    assign mode_e = cnt_mode_e'(mode);
    assign step   = tick & en_q & run_q & ~restart;

    always_comb begin
        cnt_nxt = cnt_q;
        dir_n   = dir_q;
        if (dir_q == DIR_UP) begin
            if (mode_e == MODE_UP_RC && cnt_q == rc) begin
                cnt_nxt = '0;
            end else if (mode_e == MODE_UPDN_RC && cnt_q == rc) begin
                if (cnt_q == '0) begin
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt_q - ONE;
                    dir_n   = DIR_DOWN;
                end
            end else if (cnt_q == TOP) begin
                if (mode_e == MODE_UPDN_MAX || mode_e == MODE_UPDN_RC) begin
                    cnt_nxt = TOP - ONE;
                    dir_n   = DIR_DOWN;
                end else begin
                    cnt_nxt = '0;
                end
            end else begin
                cnt_nxt = cnt_q + ONE;
            end
        end else begin
            if (cnt_q == '0) begin
                cnt_nxt = ONE;
                dir_n   = DIR_UP;
            end else begin
                cnt_nxt = cnt_q - ONE;
            end
        end
    end

    assign ovf    = step && (cnt_q == TOP);
    assign rc_hit = step && (cnt_nxt == rc);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            dir_q <= DIR_UP;
            run_q <= 1'b0;
        end else if (restart) begin
            cnt_q <= '0;
            dir_q <= DIR_UP;
            run_q <= 1'b1;
        end else if (step) begin
            cnt_q <= cnt_nxt;
            dir_q <= dir_n;
            if (rc_hit && stop_rc) run_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                   en_q <= 1'b0;
        else if (clk_on)           en_q <= 1'b1;
        else if (rc_hit && dis_rc) en_q <= 1'b0;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/tcw_out_line.sv
module tcw_out_line
    import tcw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_evt_t evt,
    input  line_act_t act,
    output logic      line
);

    logic     line_q;
    out_act_e sel_act;

    assign sel_act = pick_act(evt, act);

    always_ff @(posedge clk) begin
        if (rst) line_q <= 1'b0;
        else     line_q <= apply_act(line_q, sel_act);
    end

    assign line = line_q;

endmodule

// File: rtl/tcw_channel.sv
module tcw_channel
    import tcw_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_tick,
    input  logic             sw_trig,
    input  logic             blk_trig,
    input  logic             ext_evt_in,
    input  logic             clk_on,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       cfg_mode,
    input  logic [1:0]       cfg_ext_edge,
    input  logic             cfg_etrg_en,
    input  logic             cfg_stop_rc,
    input  logic             cfg_dis_rc,
    input  logic [1:0]       cfg_a_ra,
    input  logic [1:0]       cfg_a_rc,
    input  logic [1:0]       cfg_a_ext,
    input  logic [1:0]       cfg_a_sw,
    input  logic [1:0]       cfg_b_rb,
    input  logic [1:0]       cfg_b_rc,
    input  logic [1:0]       cfg_b_ext,
    input  logic [1:0]       cfg_b_sw,
    output logic [CNT_W-1:0] cnt_val,
    output logic             tio_a,
    output logic             tio_b,
    output logic             st_covf,
    output logic             st_cpa,
    output logic             st_cpb,
    output logic             st_cpc,
    output logic             st_etrg
);

    localparam int N_LINES = 2;

    logic [CNT_W-1:0] ra_q;
    logic [CNT_W-1:0] rb_q;
    logic [CNT_W-1:0] rc_q;

    logic             ext_evt;
    logic             sw_any;
    logic             restart;
    logic [CNT_W-1:0] cnt_nxt;
    logic             step;
    logic             ovf;
    logic             rc_hit;
    logic             ra_hit;
    logic             rb_hit;

    line_evt_t        evt_arr  [N_LINES];
    line_act_t        act_arr  [N_LINES];
    logic             line_arr [N_LINES];

    // compare / period registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ra_q <= '0;
            rb_q <= '0;
            rc_q <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_RA:  ra_q <= wr_data;
                SEL_RB:  rb_q <= wr_data;
                SEL_RC:  rc_q <= wr_data;
                default: ;
            endcase
        end
    end

    tcw_edge_det u_edge (
        .clk      (clk),
        .rst      (rst),
        .sig_in   (ext_evt_in),
        .edge_sel (cfg_ext_edge),
        .evt      (ext_evt)
    );

    assign sw_any  = sw_trig | blk_trig;
    assign restart = sw_any | (ext_evt & cfg_etrg_en);

    tcw_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (cnt_tick),
        .restart (restart),
        .clk_on  (clk_on),
        .mode    (cfg_mode),
        .rc      (rc_q),
        .stop_rc (cfg_stop_rc),
        .dis_rc  (cfg_dis_rc),
        .cnt     (cnt_val),
        .cnt_nxt (cnt_nxt),
        .step    (step),
        .ovf     (ovf),
        .rc_hit  (rc_hit)
    );

    assign ra_hit = step && (cnt_nxt == ra_q);
    assign rb_hit = step && (cnt_nxt == rb_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_covf <= 1'b0;
            st_cpa  <= 1'b0;
            st_cpb  <= 1'b0;
            st_cpc  <= 1'b0;
            st_etrg <= 1'b0;
        end else begin
            st_covf <= ovf;
            st_cpa  <= ra_hit;
            st_cpb  <= rb_hit;
            st_cpc  <= rc_hit;
            st_etrg <= ext_evt;
        end
    end

    always_comb begin
        evt_arr[0] = '{sw: sw_any, ext: ext_evt, rc: rc_hit, own: ra_hit};
        evt_arr[1] = '{sw: sw_any, ext: ext_evt, rc: rc_hit, own: rb_hit};
        act_arr[0] = '{sw: out_act_e'(cfg_a_sw), ext: out_act_e'(cfg_a_ext),
                       rc: out_act_e'(cfg_a_rc), own: out_act_e'(cfg_a_ra)};
        act_arr[1] = '{sw: out_act_e'(cfg_b_sw), ext: out_act_e'(cfg_b_ext),
                       rc: out_act_e'(cfg_b_rc), own: out_act_e'(cfg_b_rb)};
    end

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        tcw_out_line u_line (
            .clk  (clk),
            .rst  (rst),
            .evt  (evt_arr[g]),
            .act  (act_arr[g]),
            .line (line_arr[g])
        );
    end

    assign tio_a = line_arr[0];
    assign tio_b = line_arr[1];

endmodule

// File: rtl/tcw_channel_chk.sv
module tcw_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cnt_tick,
    input logic             sw_trig,
    input logic             blk_trig,
    input logic             cfg_etrg_en,
    input logic             wr_en,
    input logic [1:0]       cfg_a_sw,
    input logic [CNT_W-1:0] cnt_val,
    input logic             tio_a,
    input logic             st_covf,
    input logic             st_cpa,
    input logic             st_cpb,
    input logic             st_cpc,
    input logic [CNT_W-1:0] ra_q,
    input logic [CNT_W-1:0] rb_q,
    input logic [CNT_W-1:0] rc_q
);

    localparam logic [CNT_W-1:0] TOP = '1;

    AST_STEP_SHAPE: assert property (@(posedge clk) disable iff (rst)
        !$stable(cnt_val) |-> (cnt_val == CNT_W'($past(cnt_val) + 1'b1) ||
                               cnt_val == CNT_W'($past(cnt_val) - 1'b1) ||
                               cnt_val == '0)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cnt_tick && !sw_trig && !blk_trig && !cfg_etrg_en) |=> $stable(cnt_val)); // R2

    AST_TRIG_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (sw_trig || blk_trig) |=> (cnt_val == '0)); // R9

    AST_OVF_POSITION: assert property (@(posedge clk) disable iff (rst)
        st_covf |-> (cnt_val == '0 || cnt_val == TOP - 1'b1)); // R3

    AST_CPA_VALUE: assert property (@(posedge clk) disable iff (rst)
        (st_cpa && !$past(wr_en)) |-> (cnt_val == ra_q)); // R7

    AST_CPB_VALUE: assert property (@(posedge clk) disable iff (rst)
        (st_cpb && !$past(wr_en)) |-> (cnt_val == rb_q)); // R7

    AST_CPC_VALUE: assert property (@(posedge clk) disable iff (rst)
        (st_cpc && !$past(wr_en)) |-> (cnt_val == rc_q)); // R7

    AST_NO_CMP_ON_TRIG: assert property (@(posedge clk) disable iff (rst)
        (sw_trig || blk_trig) |=> !(st_cpa || st_cpb || st_cpc)); // R7

    AST_SW_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        ((sw_trig || blk_trig) && cfg_a_sw == 2'b01) |=> tio_a); // R11

endmodule

bind tcw_channel tcw_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cnt_tick    (cnt_tick),
    .sw_trig     (sw_trig),
    .blk_trig    (blk_trig),
    .cfg_etrg_en (cfg_etrg_en),
    .wr_en       (wr_en),
    .cfg_a_sw    (cfg_a_sw),
    .cnt_val     (cnt_val),
    .tio_a       (tio_a),
    .st_covf     (st_covf),
    .st_cpa      (st_cpa),
    .st_cpb      (st_cpb),
    .st_cpc      (st_cpc),
    .ra_q        (ra_q),
    .rb_q        (rb_q),
    .rc_q        (rc_q)
);

// File: tb/tcw_channel_tb.sv
module tcw_channel_tb;

    localparam int CNT_W    = 4;
    localparam int CLK_HALF = 5;
    localparam int CLK_PER  = 2 * CLK_HALF;
    localparam int TOPV     = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst;
    logic             cnt_tick, sw_trig, blk_trig, ext_evt_in, clk_on, wr_en;
    logic [1:0]       wr_sel;
    logic [CNT_W-1:0] wr_data;
    logic [1:0]       cfg_mode, cfg_ext_edge;
    logic             cfg_etrg_en, cfg_stop_rc, cfg_dis_rc;
    logic [1:0]       cfg_a_ra, cfg_a_rc, cfg_a_ext, cfg_a_sw;
    logic [1:0]       cfg_b_rb, cfg_b_rc, cfg_b_ext, cfg_b_sw;
    logic [CNT_W-1:0] cnt_val;
    logic             tio_a, tio_b, st_covf, st_cpa, st_cpb, st_cpc, st_etrg;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #(CLK_HALF) clk = ~clk;

    tcw_channel #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .cnt_tick(cnt_tick), .sw_trig(sw_trig),
        .blk_trig(blk_trig), .ext_evt_in(ext_evt_in), .clk_on(clk_on),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cfg_mode(cfg_mode), .cfg_ext_edge(cfg_ext_edge),
        .cfg_etrg_en(cfg_etrg_en), .cfg_stop_rc(cfg_stop_rc),
        .cfg_dis_rc(cfg_dis_rc), .cfg_a_ra(cfg_a_ra), .cfg_a_rc(cfg_a_rc),
        .cfg_a_ext(cfg_a_ext), .cfg_a_sw(cfg_a_sw), .cfg_b_rb(cfg_b_rb),
        .cfg_b_rc(cfg_b_rc), .cfg_b_ext(cfg_b_ext), .cfg_b_sw(cfg_b_sw),
        .cnt_val(cnt_val), .tio_a(tio_a), .tio_b(tio_b), .st_covf(st_covf),
        .st_cpa(st_cpa), .st_cpb(st_cpb), .st_cpc(st_cpc), .st_etrg(st_etrg)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick1();
        cnt_tick = 1'b1;
        @(negedge clk);
        cnt_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick1();
    endtask

    task automatic swtrig();
        sw_trig = 1'b1;
        @(negedge clk);
        sw_trig = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sel, input int d);
        wr_en = 1'b1; wr_sel = sel; wr_data = CNT_W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ext_to(input logic v);
        ext_evt_in = v;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int p;
        int ea;
        int eb;
        rst = 1'b1;
        cnt_tick = 0; sw_trig = 0; blk_trig = 0; ext_evt_in = 0; clk_on = 0;
        wr_en = 0; wr_sel = 0; wr_data = 0;
        cfg_mode = 0; cfg_ext_edge = 0; cfg_etrg_en = 0; cfg_stop_rc = 0; cfg_dis_rc = 0;
        cfg_a_ra = 0; cfg_a_rc = 0; cfg_a_ext = 0; cfg_a_sw = 0;
        cfg_b_rb = 0; cfg_b_rc = 0; cfg_b_ext = 0; cfg_b_sw = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 cnt", cnt_val, 0);
        chk("R1 tio_a", tio_a, 0);
        chk("R1 tio_b", tio_b, 0);
        chk("R1 flags", {st_covf, st_cpa, st_cpb, st_cpc, st_etrg}, 0);
        ticks(3);
        chk("R1 idle after reset", cnt_val, 0);

        // R2 gating: clock on but not running
        clk_on = 1'b1; @(negedge clk); clk_on = 1'b0;
        ticks(2);
        chk("R2 not running", cnt_val, 0);
        swtrig();
        ticks(3);
        chk("R2 three steps", cnt_val, 3);
        repeat (2) @(negedge clk);
        chk("R2 no strobe holds", cnt_val, 3);

        // R3 wrap profile
        cfg_mode = 2'b00;
        swtrig();
        for (int n = 1; n <= 34; n++) begin
            tick1();
            chk("R3 wrap count", cnt_val, n % (TOPV + 1));
            chk("R3 overflow flag", st_covf, ((n % (TOPV + 1)) == 0) ? 1 : 0);
        end

        // R5 triangle to all-ones
        cfg_mode = 2'b10;
        swtrig();
        for (int n = 1; n <= 62; n++) begin
            tick1();
            p = n % (2 * TOPV);
            chk("R5 triangle count", cnt_val, (p <= TOPV) ? p : 2 * TOPV - p);
            chk("R5 overflow flag", st_covf, (p == TOPV + 1) ? 1 : 0);
        end

        // R4 restart at period, swept over all periods
        cfg_mode = 2'b01;
        for (int rc = 1; rc <= TOPV; rc++) begin
            wr(2'b10, rc);
            swtrig();
            chk("R9 trigger zeroes", cnt_val, 0);
            for (int n = 1; n <= 2 * rc + 3; n++) begin
                tick1();
                chk("R4 period count", cnt_val, n % (rc + 1));
            end
        end

        // R6 triangle to period, swept
        cfg_mode = 2'b11;
        for (int rc = 1; rc <= TOPV; rc++) begin
            wr(2'b10, rc);
            swtrig();
            for (int n = 1; n <= 4 * rc; n++) begin
                tick1();
                p = n % (2 * rc);
                chk("R6 period triangle", cnt_val, (p <= rc) ? p : 2 * rc - p);
            end
        end

        // R7 / R8 compare flags and line actions
        cfg_mode = 2'b01;
        wr(2'b00, 3); wr(2'b01, 5); wr(2'b10, 9);
        cfg_a_ra = 2'b01; cfg_a_rc = 2'b10; cfg_b_rb = 2'b11; cfg_b_rc = 2'b00;
        swtrig();
        ea = tio_a; eb = tio_b;
        chk("R8 lines start low", ea + eb, 0);
        for (int n = 1; n <= 25; n++) begin
            tick1();
            p = n % 10;
            if (p == 3) ea = 1;
            if (p == 9) ea = 0;
            if (p == 5) eb = 1 - eb;
            chk("R7 count unaffected by compares", cnt_val, p);
            chk("R7 cpa", st_cpa, (p == 3) ? 1 : 0);
            chk("R7 cpb", st_cpb, (p == 5) ? 1 : 0);
            chk("R7 cpc", st_cpc, (p == 9) ? 1 : 0);
            chk("R8 tio_a", tio_a, ea);
            chk("R8 tio_b", tio_b, eb);
        end
        wr(2'b00, 0);
        swtrig();
        chk("R7 no compare on restart", st_cpa, 0);

        // R9 trigger actions
        cfg_a_sw = 2'b11; cfg_b_sw = 2'b10;
        swtrig();
        chk("R9 sw toggle a", tio_a, 1 - ea);
        chk("R9 sw clear b", tio_b, 0);
        cfg_a_sw = 2'b01; cfg_b_sw = 2'b01;
        ticks(2);
        blk_trig = 1'b1; @(negedge clk); blk_trig = 1'b0;
        chk("R9 blk zeroes", cnt_val, 0);
        chk("R9 blk set a", tio_a, 1);
        chk("R9 blk set b", tio_b, 1);

        // R10 external events
        cfg_a_sw = 0; cfg_b_sw = 0; cfg_a_ra = 0; cfg_a_rc = 0; cfg_b_rb = 0;
        cfg_mode = 2'b00;
        cfg_ext_edge = 2'b01; cfg_etrg_en = 1'b1; cfg_a_ext = 2'b11;
        ticks(5);
        chk("R10 pre count", cnt_val, 5);
        ext_to(1'b1);
        chk("R10 rise restarts", cnt_val, 0);
        chk("R10 etrg flag", st_etrg, 1);
        chk("R10 ext toggles a", tio_a, 0);
        ticks(3);
        chk("R10 counts after restart", cnt_val, 3);
        ext_to(1'b0);
        chk("R10 fall ignored when rising selected", cnt_val, 3);
        chk("R10 no flag on fall", st_etrg, 0);
        cfg_ext_edge = 2'b11;
        ext_to(1'b1);
        chk("R10 either edge restarts", cnt_val, 0);
        cfg_ext_edge = 2'b00;
        ticks(2);
        ext_to(1'b0);
        chk("R10 none code ignored", cnt_val, 2);
        chk("R10 none no flag", st_etrg, 0);
        cfg_ext_edge = 2'b10;
        ext_to(1'b1);
        chk("R10 rise ignored when falling selected", cnt_val, 2);
        ext_to(1'b0);
        chk("R10 fall restarts", cnt_val, 0);
        cfg_ext_edge = 2'b01; cfg_etrg_en = 1'b0;
        ticks(2);
        ea = tio_a;
        ext_to(1'b1);
        chk("R10 no restart when disabled", cnt_val, 2);
        chk("R10 flag without restart", st_etrg, 1);
        chk("R10 action without restart", tio_a, 1 - ea);
        ext_to(1'b0);

        // R11 priorities
        cfg_mode = 2'b01; wr(2'b10, 4);
        cfg_a_rc = 2'b10; cfg_a_ext = 2'b01;
        swtrig();
        ticks(3);
        ext_evt_in = 1'b1; tick1();
        chk("R11 landed on period", cnt_val, 4);
        chk("R11 period flag", st_cpc, 1);
        chk("R11 ext over period", tio_a, 1);
        ext_to(1'b0);
        cfg_a_sw = 2'b10;
        sw_trig = 1'b1; ext_evt_in = 1'b1;
        @(negedge clk);
        sw_trig = 1'b0;
        chk("R11 sw over ext", tio_a, 0);
        ext_to(1'b0);
        cfg_a_sw = 0; cfg_a_ext = 0;
        wr(2'b00, 2); wr(2'b10, 2);
        cfg_a_ra = 2'b01; cfg_a_rc = 2'b10;
        swtrig();
        ticks(2);
        chk("R11 period over own compare", tio_a, 0);
        cfg_a_ra = 0; cfg_a_rc = 0;

        // R12 stop on period
        cfg_mode = 2'b00; wr(2'b10, 4); cfg_stop_rc = 1'b1;
        swtrig();
        ticks(8);
        chk("R12 halted at period", cnt_val, 4);
        swtrig();
        ticks(2);
        chk("R12 resumes after restart", cnt_val, 2);
        cfg_stop_rc = 1'b0;

        // R13 disable on period
        cfg_dis_rc = 1'b1;
        swtrig();
        ticks(8);
        chk("R13 disabled at period", cnt_val, 4);
        swtrig();
        ticks(3);
        chk("R13 restart alone insufficient", cnt_val, 0);
        cfg_dis_rc = 1'b0;
        clk_on = 1'b1; @(negedge clk); clk_on = 1'b0;
        ticks(3);
        chk("R13 counts after clk_on", cnt_val, 3);

        // R14 write select 11 changes nothing
        cfg_mode = 2'b01;
        wr(2'b00, 1);
        wr(2'b11, 3);
        swtrig();
        tick1();
        chk("R14 first compare kept", st_cpa, 1);
        ticks(2);
        chk("R14 no compare at unwritten value", st_cpa, 0);
        ticks(2);
        chk("R14 period kept", cnt_val, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule